// File: doc/BRIEF.md
# SDRAM Mode Register and Read-Latency Sequencer

This block is the device-side control path of a synchronous DRAM column interface. A decoded command arrives on each rising clock edge. A mode-load command programs three settings: the read latency, the burst length, and whether writes are single-location. READ and WRITE commands then start a burst. The block steps the column address from beat to beat, wrapping inside the aligned burst window, and drives a per-beat access strobe and column toward a small internal storage array.

For reads, the beat columns pass through a short latency pipeline. The data-pin output enable rises one cycle before the first read beat is marked valid. It stays on until the cycle after the last valid beat. A new READ or WRITE cuts off the beat stream of the burst in progress. Read beats already issued still come out of the pipeline in order. A mode word that selects a reserved operating mode, burst code or latency code sets an error flag, and the previous settings are kept.

Top module: `sdram_lat_seq`

## Requirements
- R1: Out of reset all outputs are low and the settings are latency 2, burst length 1, writes bursting. A READ issued before any mode load therefore gives one valid beat.
- R2: Read latency comes from mode bits [6:4]: 001, 010 and 011 select 1, 2 and 3 cycles. For a READ registered at edge n with latency m, `rd_valid_o` is first high in the cycle after edge n+m.
- R3: `dq_oe_o` rises after edge n+m-1, one cycle before the first valid beat. It stays high through the last valid beat and falls at the edge where `rd_valid_o` falls.
- R4: Burst length comes from mode bits [2:0]: 000, 001, 010 and 011 select 1, 2, 4 and 8 beats. Beat k of a burst registered at edge n is issued in the cycle after edge n+k.
- R5: For burst length L, beat k uses the starting column with its low log2(L) bits replaced by (start + k) mod L. The upper bits do not change. Read data come out carrying the column of the beat that issued them.
- R6: With mode bit 9 clear, a WRITE issues L write beats. With mode bit 9 set, a WRITE issues exactly one write beat, while a READ still issues L beats.
- R7: A mode load with bits [8:7] not 00 sets `mode_err_o` in the cycle after it, and leaves latency, burst length and write mode unchanged.
- R8: A mode load with a reserved burst code (bit 2 set) or a reserved latency code (000, 1xx) also sets `mode_err_o` and changes nothing. A valid mode load clears `mode_err_o`.
- R9: A READ or WRITE registered during a burst ends the issue of the old beats from that edge. Read beats issued before it are still delivered, in order, followed by the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 00 NOP, 01 mode load, 10 READ, 11 WRITE |
| col_i | input | COL_W | Starting column for READ/WRITE |
| mode_i | input | 10 | Mode word, sampled on mode load |
| acc_rd_o | output | 1 | Read beat issued to storage this cycle |
| acc_wr_o | output | 1 | Write beat issued to storage this cycle |
| acc_col_o | output | COL_W | Column of the issued beat |
| rd_valid_o | output | 1 | Read data valid this cycle |
| rd_col_o | output | COL_W | Column of the valid read beat |
| dq_oe_o | output | 1 | Data-pin output enable |
| mode_err_o | output | 1 | Last mode load used a reserved setting |

## Verification
The case that needs care is a new command arriving while an older read is still in the latency pipeline. The output stage is then delivering old beats while the issue stage is truncating the old burst and starting a new one, and both happen in the same cycle. The bench provokes this with an 8-beat read at latency 3 that is interrupted after three beats by a second read, and with a 4-beat read that is interrupted by a write. On each new command, the scoreboard drops the expected beats from that edge on, but keeps the pipeline items already issued. It then compares every cycle's strobes, columns and output enable against the queue. The total beat counts confirm that the old and new streams follow each other with no gap and no overlap.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_LOAD  = 2'b01,
        CMD_READ  = 2'b10,
        CMD_WRITE = 2'b11
    } cmd_e;

    localparam int MODE_W   = 10;
    localparam int MAX_LAT  = 3;
    localparam int MAX_BLEN = 8;
    localparam int BLEN_W   = $clog2(MAX_BLEN) + 1;
    localparam int LOW_W    = $clog2(MAX_BLEN);
    localparam int LAT_W    = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [LAT_W-1:0]  cas_lat;
        logic [BLEN_W-1:0] blen;
        logic              wr_single;
    } mode_cfg_t;

    localparam mode_cfg_t MODE_RESET = '{cas_lat: LAT_W'(2), blen: BLEN_W'(1), wr_single: 1'b0};

    function automatic logic blen_code_ok(input logic [2:0] code);
        return code[2] == 1'b0;
    endfunction

    function automatic logic [BLEN_W-1:0] blen_decode(input logic [2:0] code);
        return BLEN_W'(1) << code[1:0];
    endfunction

    function automatic logic lat_code_ok(input logic [2:0] code);
        return (code != 3'd0) && (code <= 3'(MAX_LAT));
    endfunction

    function automatic logic [LAT_W-1:0] lat_decode(input logic [2:0] code);
        return code[LAT_W-1:0];
    endfunction

    function automatic logic mode_word_ok(input logic [MODE_W-1:0] w);
        return (w[8:7] == 2'b00) && blen_code_ok(w[2:0]) && lat_code_ok(w[6:4]);
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [MODE_W-1:0] mode_word,
    output mode_cfg_t         cfg_o,
    output logic              err_o
);

    mode_cfg_t cfg_q;
    logic      err_q;
    logic      word_ok;

    always_comb begin
        word_ok = mode_word_ok(mode_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= MODE_RESET;
            err_q <= 1'b0;
        end else if (load_en) begin
            if (word_ok) begin
                cfg_q.cas_lat   <= lat_decode(mode_word[6:4]);
                cfg_q.blen      <= blen_decode(mode_word[2:0]);
                cfg_q.wr_single <= mode_word[9];
                err_q           <= 1'b0;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    assign cfg_o = cfg_q;
    assign err_o = err_q;

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
    import sdram_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_rd,
    input  logic             start_wr,
    input  logic [COL_W-1:0] col_i,
    input  mode_cfg_t        cfg_i,
    output logic             rd_o,
    output logic             wr_o,
    output logic [COL_W-1:0] col_o
);

    logic              active_q;
    logic              is_rd_q;
    logic [LOW_W-1:0]  left_q;
    logic [LOW_W-1:0]  mask_q;
    logic [COL_W-1:0]  col_q;

    logic [BLEN_W-1:0] start_len;
    logic [BLEN_W-1:0] len_m1;
    logic [BLEN_W-1:0] mask_full;
    logic [LOW_W-1:0]  low_inc;
    logic [COL_W-1:0]  col_next;

    always_comb begin
        if (start_rd || !cfg_i.wr_single) begin
            start_len = cfg_i.blen;
        end else begin
            start_len = BLEN_W'(1);
        end
        len_m1    = start_len - BLEN_W'(1);
        mask_full = cfg_i.blen - BLEN_W'(1);
        low_inc   = col_q[LOW_W-1:0] + LOW_W'(1);
        col_next  = {col_q[COL_W-1:LOW_W],
                     (col_q[LOW_W-1:0] & ~mask_q) | (low_inc & mask_q)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            is_rd_q  <= 1'b0;
            left_q   <= '0;
            mask_q   <= '0;
            col_q    <= '0;
        end else if (start_rd || start_wr) begin
            active_q <= 1'b1;
            is_rd_q  <= start_rd;
            left_q   <= len_m1[LOW_W-1:0];
            mask_q   <= mask_full[LOW_W-1:0];
            col_q    <= col_i;
        end else if (active_q && (left_q != '0)) begin
            left_q <= left_q - LOW_W'(1);
            col_q  <= col_next;
        end else begin
            active_q <= 1'b0;
        end
    end

    assign rd_o  = active_q && is_rd_q;
    assign wr_o  = active_q && !is_rd_q;
    assign col_o = col_q;

endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe
    import sdram_seq_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int DEPTH = MAX_LAT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [COL_W-1:0] in_col,
    input  logic [LAT_W-1:0] lat,
    output logic             vld_o,
    output logic [COL_W-1:0] col_o,
    output logic             oe_o
);

    logic [DEPTH:0]   stage_v;
    logic [COL_W-1:0] stage_c [DEPTH+1];
    logic [LAT_W-1:0] lat_prev;

    assign stage_v[0] = in_vld;
    assign stage_c[0] = in_col;

    for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_v[g] <= 1'b0;
                stage_c[g] <= '0;
            end else begin
                stage_v[g] <= stage_v[g-1];
                stage_c[g] <= stage_c[g-1];
            end
        end
    end

    always_comb begin
        lat_prev = lat - LAT_W'(1);
        vld_o    = stage_v[lat];
        col_o    = stage_c[lat];
        oe_o     = stage_v[lat] | stage_v[lat_prev];
    end

endmodule

// File: rtl/sdram_lat_seq.sv
module sdram_lat_seq
    import sdram_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              acc_rd_o,
    output logic              acc_wr_o,
    output logic [COL_W-1:0]  acc_col_o,
    output logic              rd_valid_o,
    output logic [COL_W-1:0]  rd_col_o,
    output logic              dq_oe_o,
    output logic              mode_err_o
);

    cmd_e      cmd;
    mode_cfg_t cfg;
    logic      beat_rd;
    logic      beat_wr;
    logic [COL_W-1:0] beat_col;

    assign cmd = cmd_e'(cmd_i);

    sdram_mode_reg u_mode (
        .clk       (clk),
        .rst       (rst),
        .load_en   (cmd == CMD_LOAD),
        .mode_word (mode_i),
        .cfg_o     (cfg),
        .err_o     (mode_err_o)
    );

    sdram_burst_gen #(.COL_W(COL_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .start_rd (cmd == CMD_READ),
        .start_wr (cmd == CMD_WRITE),
        .col_i    (col_i),
        .cfg_i    (cfg),
        .rd_o     (beat_rd),
        .wr_o     (beat_wr),
        .col_o    (beat_col)
    );

    sdram_read_pipe #(.COL_W(COL_W), .DEPTH(MAX_LAT)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .in_vld (beat_rd),
        .in_col (beat_col),
        .lat    (cfg.cas_lat),
        .vld_o  (rd_valid_o),
        .col_o  (rd_col_o),
        .oe_o   (dq_oe_o)
    );

    assign acc_rd_o  = beat_rd;
    assign acc_wr_o  = beat_wr;
    assign acc_col_o = beat_col;

endmodule

// File: rtl/sdram_lat_seq_chk.sv
module sdram_lat_seq_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cmd_i,
    input logic [9:0]       mode_i,
    input logic             acc_rd_o,
    input logic             acc_wr_o,
    input logic [COL_W-1:0] acc_col_o,
    input logic             rd_valid_o,
    input logic             dq_oe_o,
    input logic             mode_err_o
);

    // R3
    oe_leads_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid_o) |-> $past(dq_oe_o));

    // R3
    oe_falls_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_oe_o) |-> $past(rd_valid_o));

    // R5
    burst_upper_col_chk: assert property (@(posedge clk) disable iff (rst)
        ((acc_rd_o || acc_wr_o) && $past(acc_rd_o || acc_wr_o) && !$past(cmd_i[1]))
        |-> (acc_col_o[COL_W-1:3] == $past(acc_col_o[COL_W-1:3])));

    // R7
    bad_opmode_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'b01 && mode_i[8:7] != 2'b00) |=> mode_err_o);

    // R8
    good_load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'b01 && mode_i[8:7] == 2'b00 && !mode_i[2] &&
         mode_i[6:4] != 3'd0 && !mode_i[6]) |=> !mode_err_o);

    // R9
    one_beat_kind_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_rd_o && acc_wr_o));

endmodule

bind sdram_lat_seq sdram_lat_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd_i),
    .mode_i     (mode_i),
    .acc_rd_o   (acc_rd_o),
    .acc_wr_o   (acc_wr_o),
    .acc_col_o  (acc_col_o),
    .rd_valid_o (rd_valid_o),
    .dq_oe_o    (dq_oe_o),
    .mode_err_o (mode_err_o)
);

// File: tb/tb_sdram_lat_seq.sv
module tb_sdram_lat_seq;
    import sdram_seq_pkg::*;

    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       cmd_i;
    logic [COL_W-1:0] col_i;
    logic [9:0]       mode_i;
    logic             acc_rd_o, acc_wr_o, rd_valid_o, dq_oe_o, mode_err_o;
    logic [COL_W-1:0] acc_col_o, rd_col_o;

    always #10 clk = ~clk;

    sdram_lat_seq #(.COL_W(COL_W)) dut (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .col_i(col_i), .mode_i(mode_i),
        .acc_rd_o(acc_rd_o), .acc_wr_o(acc_wr_o), .acc_col_o(acc_col_o),
        .rd_valid_o(rd_valid_o), .rd_col_o(rd_col_o), .dq_oe_o(dq_oe_o),
        .mode_err_o(mode_err_o)
    );

    typedef struct {
        int               cyc;
        bit               rd;
        logic [COL_W-1:0] col;
    } item_t;

    item_t accq[$];
    item_t rdq[$];

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int rd_seen = 0;
    int wr_seen = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    int m_cl = 2;
    int m_bl = 1;
    bit m_single = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [9:0] mw(input bit single, input logic [1:0] opm,
                                      input logic [2:0] cl, input logic [2:0] blc);
        return {single, opm, cl, 1'b0, blc};
    endfunction

    function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] base,
                                                  input int k, input int bl);
        logic [2:0] m;
        logic [2:0] lo;
        m  = 3'(bl - 1);
        lo = 3'(int'(base[2:0]) + k);
        return {base[COL_W-1:3], (base[2:0] & ~m) | (lo & m)};
    endfunction

    task automatic drive(input cmd_e c, input logic [COL_W-1:0] col, input logic [9:0] w);
        int n;
        int len;
        @(negedge clk);
        cmd_i  = c;
        col_i  = col;
        mode_i = w;
        n = cyc + 1;
        if (c == CMD_READ || c == CMD_WRITE) begin
            while (accq.size() > 0 && accq[$].cyc >= n) void'(accq.pop_back());
            while (rdq.size() > 0 && rdq[$].cyc >= n + m_cl) void'(rdq.pop_back());
            len = (c == CMD_READ || !m_single) ? m_bl : 1;
            for (int k = 0; k < len; k++) begin
                accq.push_back('{cyc: n + k, rd: (c == CMD_READ), col: beat_col(col, k, m_bl)});
                if (c == CMD_READ)
                    rdq.push_back('{cyc: n + k + m_cl, rd: 1'b1, col: beat_col(col, k, m_bl)});
            end
        end else if (c == CMD_LOAD) begin
            if (w[8:7] == 2'b00 && !w[2] && w[6:4] >= 3'd1 && w[6:4] <= 3'd3) begin
                m_cl     = int'(w[6:4]);
                m_bl     = 1 << w[1:0];
                m_single = w[9];
            end
        end
    endtask

    task automatic idle(input int k);
        repeat (k) begin
            @(negedge clk);
            cmd_i = CMD_NOP;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_en) begin
            bit exp_v, exp_n, exp_a, exp_rd;
            exp_v = (rdq.size() > 0) && (rdq[0].cyc == cyc);
            check(rd_valid_o == exp_v, "R2", "rd_valid", rd_valid_o, exp_v);
            if (rd_valid_o) rd_seen++;
            if (exp_v) begin
                check(rd_col_o == rdq[0].col, "R5", "rd_col", rd_col_o, rdq[0].col);
                void'(rdq.pop_front());
            end
            exp_n = (rdq.size() > 0) && (rdq[0].cyc == cyc + 1);
            check(dq_oe_o == (exp_v || exp_n), "R3", "dq_oe", dq_oe_o, exp_v || exp_n);
            exp_a  = (accq.size() > 0) && (accq[0].cyc == cyc);
            exp_rd = exp_a && accq[0].rd;
            check(acc_rd_o == exp_rd, "R4", "acc_rd", acc_rd_o, exp_rd);
            check(acc_wr_o == (exp_a && !exp_rd), "R6", "acc_wr", acc_wr_o, exp_a && !exp_rd);
            if (acc_wr_o) wr_seen++;
            if (exp_a) begin
                check(acc_col_o == accq[0].col, "R5", "acc_col", acc_col_o, accq[0].col);
                void'(accq.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_i = CMD_NOP; col_i = '0; mode_i = '0;
        repeat (3) @(negedge clk);
        check(!rd_valid_o && !dq_oe_o, "R1", "reset rd/oe", {rd_valid_o, dq_oe_o}, 0);
        check(!acc_rd_o && !acc_wr_o, "R1", "reset acc", {acc_rd_o, acc_wr_o}, 0);
        check(!mode_err_o, "R1", "reset err", mode_err_o, 0);
        @(negedge clk);
        rst = 1'b0;
        mon_en = 1'b1;

        // R1 default settings: latency 2, one beat
        rd_seen = 0;
        drive(CMD_READ, 8'h05, '0); idle(8);
        check(rd_seen == 1, "R1", "default beats", rd_seen, 1);

        // R2 R4 R5 latency 1, length 4, wrap
        drive(CMD_LOAD, '0, mw(0, 2'b00, 3'd1, 3'b010)); idle(2);
        rd_seen = 0;
        drive(CMD_READ, 8'h1E, '0); idle(10);
        check(rd_seen == 4, "R4", "bl4 beats", rd_seen, 4);

        // latency 3, length 8, wrap
        drive(CMD_LOAD, '0, mw(0, 2'b00, 3'd3, 3'b011)); idle(2);
        rd_seen = 0;
        drive(CMD_READ, 8'h45, '0); idle(14);
        check(rd_seen == 8, "R4", "bl8 beats", rd_seen, 8);

        // latency 2, length 2, plus back-to-back
        drive(CMD_LOAD, '0, mw(0, 2'b00, 3'd2, 3'b001)); idle(2);
        rd_seen = 0;
        drive(CMD_READ, 8'hA3, '0); idle(1);
        drive(CMD_READ, 8'h40, '0); idle(8);
        check(rd_seen == 4, "R2", "bl2 back-to-back beats", rd_seen, 4);

        // R6 bursting writes
        drive(CMD_LOAD, '0, mw(0, 2'b00, 3'd2, 3'b010)); idle(2);
        wr_seen = 0;
        drive(CMD_WRITE, 8'h2D, '0); idle(8);
        check(wr_seen == 4, "R6", "burst write beats", wr_seen, 4);

        // R6 single-location writes, bursting reads
        drive(CMD_LOAD, '0, mw(1, 2'b00, 3'd2, 3'b010)); idle(2);
        wr_seen = 0;
        drive(CMD_WRITE, 8'h2D, '0); idle(8);
        check(wr_seen == 1, "R6", "single write beats", wr_seen, 1);
        rd_seen = 0;
        drive(CMD_READ, 8'h62, '0); idle(10);
        check(rd_seen == 4, "R6", "read still bursts", rd_seen, 4);

        // R7 reserved operating modes
        for (int op = 1; op < 4; op++) begin
            drive(CMD_LOAD, '0, mw(0, 2'(op), 3'd1, 3'b000)); idle(1);
            check(mode_err_o == 1'b1, "R7", "opmode err", mode_err_o, 1);
        end
        idle(2);
        rd_seen = 0; wr_seen = 0;
        drive(CMD_READ, 8'h70, '0); idle(10);
        check(rd_seen == 4, "R7", "settings kept (read)", rd_seen, 4);
        drive(CMD_WRITE, 8'h70, '0); idle(6);
        check(wr_seen == 1, "R7", "settings kept (write)", wr_seen, 1);

        // R8 reserved length and latency codes
        drive(CMD_LOAD, '0, mw(0, 2'b00, 3'd2, 3'b100)); idle(1);
        check(mode_err_o == 1'b1, "R8", "bl code err", mode_err_o, 1);
        drive(CMD_LOAD, '0, mw(0, 2'b00, 3'd0, 3'b000)); idle(1);
        check(mode_err_o == 1'b1, "R8", "cl 000 err", mode_err_o, 1);
        drive(CMD_LOAD, '0, mw(0, 2'b00, 3'd5, 3'b000)); idle(2);
        check(mode_err_o == 1'b1, "R8", "cl 101 err", mode_err_o, 1);
        rd_seen = 0;
        drive(CMD_READ, 8'h88, '0); idle(10);
        check(rd_seen == 4, "R8", "settings kept", rd_seen, 4);
        drive(CMD_LOAD, '0, mw(0, 2'b00, 3'd3, 3'b011)); idle(1);
        check(mode_err_o == 1'b0, "R8", "valid load clears", mode_err_o, 0);
        idle(2);

        // R9 read interrupted by read while data are in flight
        rd_seen = 0;
        drive(CMD_READ, 8'h10, '0); idle(2);
        drive(CMD_READ, 8'h26, '0); idle(16);
        check(rd_seen == 11, "R9", "read/read beats", rd_seen, 11);

        // R9 read interrupted by write
        drive(CMD_LOAD, '0, mw(0, 2'b00, 3'd2, 3'b010)); idle(2);
        rd_seen = 0; wr_seen = 0;
        drive(CMD_READ, 8'h30, '0); idle(1);
        drive(CMD_WRITE, 8'h57, '0); idle(10);
        check(rd_seen == 2, "R9", "cut read beats", rd_seen, 2);
        check(wr_seen == 4, "R9", "write beats", wr_seen, 4);
        check(rdq.size() == 0 && accq.size() == 0, "R9", "scoreboard drained",
              rdq.size() + accq.size(), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule